// File: doc/BRIEF.md
# Sized Integer ALU with Condition-Code Register

This block is the integer datapath stage of a processor core. It performs the add, subtract, compare, negate and clear families on a destination and a source operand, each at byte, word or long size. It also keeps a five-bit condition-code register made of extend, negative, zero, overflow and carry. The result word is combinational from the inputs and from the current extend bit. The condition codes are registered and change only on a clock edge where the execute strobe is high.

The extend flag is separate from carry. Only the arithmetic operations that write a result copy carry into it. The extend-carrying variants use it as the carry-in or borrow-in, so that operations wider than the data path can be chained one word at a time. In those variants zero is sticky: a zero result leaves Z as it was, so a chain of words reports zero only when every word was zero. An address-add operation works on all 32 bits and never touches the flags. Operand fetch, addressing and memory access are the job of surrounding logic.

Top module: `alu_ccr_unit`

## Requirements
- R1: While `rst_n` is low, `ccr_o` reads 0. Its bit order is X=bit 4, N=bit 3, Z=bit 2, V=bit 1, C=bit 0.
- R2: `size_i` selects the operand size: 0 is byte (bits 7:0), 1 is word (bits 15:0), and 2 or 3 is long (bits 31:0). For every opcode except address add (8), the bits of `res_o` above the selected size equal the same bits of `dst_i`.
- R3: N copies the top bit of the sized result. For the non-extend operations (add, subtract, compare and negate), Z is 1 exactly when the sized result is zero.
- R4: Add (opcode 0) gives dst+src, and subtract (opcode 2) gives dst-src. V is set on signed overflow of the sized result. C is the carry out of the sized top bit for add, or the borrow (unsigned src > dst) for subtract. X takes the same value as C.
- R5: Add-with-extend (opcode 1) gives dst+src+X, and subtract-with-extend (opcode 3) gives dst-src-X, at any size. N, V and C follow the rules of R4, and X equals C. Z is cleared when the sized result is nonzero and is otherwise left unchanged.
- R6: Compare (opcode 4) updates N, Z, V and C as subtract would. It leaves X unchanged and drives `res_o` equal to `dst_i`.
- R7: Negate (opcode 5) gives 0-dst, updates all flags, and sets C and X exactly when the sized result is nonzero. Negate-with-extend (opcode 6) gives 0-dst-X, with borrow flags as in R4 and sticky Z as in R5.
- R8: Clear (opcode 7) zeroes the sized field and sets N=0, Z=1, V=0 and C=0. It leaves X unchanged.
- R9: Address add (opcode 8) gives the full 32-bit sum of `dst_i` and the source. At byte or word size the source is sign-extended from bits 15:0, and at long size it is used whole. All flags stay unchanged.
- R10: Opcodes 9 to 15 drive `res_o` equal to `dst_i` and leave all flags unchanged.
- R11: `ccr_o` changes only on a rising clock edge where `exec_i` is high. When `exec_i` is low it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Commits the computed flags at the next rising edge |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size select |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand |
| res_o | output | 32 | Result word, with untouched upper bits |
| ccr_o | output | 5 | Condition codes {X,N,Z,V,C} |

## Verification
The bound checker watches, on every cycle, the properties that hold whatever the operand values are:
- the flags hold when the unit is idle or running a flag-neutral opcode;
- compare and clear keep X;
- X equals C after every arithmetic operation that writes a result;
- clear produces zero, Z=1 and C=0;
- bits above the selected size are preserved;
- reset clears the register.

The arithmetic values themselves are shown only by the bench's scenarios. These include the sized carry and borrow, signed overflow at each size, the sticky zero across a carry chain and the sign extension of address add. The bench fixes the extend bit before each case, so those flag values are known.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 4;
    localparam int SIZE_W = 2;
    localparam int NLANES = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDX = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBX = 4'd3,
        OP_CMP  = 4'd4,
        OP_NEG  = 4'd5,
        OP_NEGX = 4'd6,
        OP_CLR  = 4'd7,
        OP_ADDA = 4'd8
    } alu_op_e;

    localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
    localparam logic [SIZE_W-1:0] SZ_WORD = 2'd1;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        ccr_t ccr;
    } alu_state_t;

endpackage

// File: rtl/alu_lane_add.sv
module alu_lane_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] p_i,
    input  logic [W-1:0] q_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W:0] full;

    always_comb begin
        full   = {1'b0, p_i} + {1'b0, q_i} + {{W{1'b0}}, cin_i};
        sum_o  = full[W-1:0];
        cout_o = full[W];
        // signed overflow: both addends share a sign that the sum lost
        ovf_o  = (p_i[W-1] == q_i[W-1]) && (full[W-1] != p_i[W-1]);
    end
endmodule

// File: rtl/alu_size_sel.sv
module alu_size_sel
    import alu_ccr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [SIZE_W-1:0]  size_i,
    input  logic [DW-1:0]      dst_i,
    input  logic [DW-1:0]      sum_i  [NLANES],
    input  logic [NLANES-1:0]  cout_i,
    input  logic [NLANES-1:0]  ovf_i,
    output logic [DW-1:0]      merged_o,
    output logic               msb_o,
    output logic               zero_o,
    output logic               cout_o,
    output logic               ovf_o
);
    localparam int BW = DW / 4;
    localparam int WW = DW / 2;

    always_comb begin
        case (size_i)
            SZ_BYTE: begin
                merged_o = {dst_i[DW-1:BW], sum_i[0][BW-1:0]};
                msb_o    = sum_i[0][BW-1];
                zero_o   = (sum_i[0][BW-1:0] == '0);
                cout_o   = cout_i[0];
                ovf_o    = ovf_i[0];
            end
            SZ_WORD: begin
                merged_o = {dst_i[DW-1:WW], sum_i[1][WW-1:0]};
                msb_o    = sum_i[1][WW-1];
                zero_o   = (sum_i[1][WW-1:0] == '0);
                cout_o   = cout_i[1];
                ovf_o    = ovf_i[1];
            end
            default: begin
                merged_o = sum_i[2];
                msb_o    = sum_i[2][DW-1];
                zero_o   = (sum_i[2] == '0);
                cout_o   = cout_i[2];
                ovf_o    = ovf_i[2];
            end
        endcase
    end
endmodule

// File: rtl/alu_ccr_unit.sv
module alu_ccr_unit
    import alu_ccr_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [DW-1:0]     src_i,
    input  logic [DW-1:0]     dst_i,
    output logic [DW-1:0]     res_o,
    output logic [4:0]        ccr_o
);
    localparam int HW = DW / 2;

    alu_state_t st_d, st_q;
    alu_op_e    op;

    logic [DW-1:0]     opnd_p, opnd_q;
    logic              carry_in, is_sub;
    logic [DW-1:0]     lane_sum  [NLANES];
    logic [NLANES-1:0] lane_cout, lane_ovf;
    logic [DW-1:0]     merged;
    logic              s_msb, s_zero, s_cout, s_ovf, flag_c;
    logic [DW-1:0]     addr_src, addr_sum;

    assign op = alu_op_e'(op_i);

    // operand steering: subtraction is p + ~q + !borrow_in
    always_comb begin
        opnd_p   = dst_i;
        opnd_q   = src_i;
        carry_in = 1'b0;
        is_sub   = 1'b0;
        case (op)
            OP_ADDX: carry_in = st_q.ccr.x;
            OP_SUB, OP_CMP: begin
                opnd_q   = ~src_i;
                carry_in = 1'b1;
                is_sub   = 1'b1;
            end
            OP_SUBX: begin
                opnd_q   = ~src_i;
                carry_in = ~st_q.ccr.x;
                is_sub   = 1'b1;
            end
            OP_NEG: begin
                opnd_p   = '0;
                opnd_q   = ~dst_i;
                carry_in = 1'b1;
                is_sub   = 1'b1;
            end
            OP_NEGX: begin
                opnd_p   = '0;
                opnd_q   = ~dst_i;
                carry_in = ~st_q.ccr.x;
                is_sub   = 1'b1;
            end
            OP_CLR: begin
                opnd_p = '0;
                opnd_q = '0;
            end
            default: ;
        endcase
    end

    // one adder per operand size, each with its own carry and overflow
    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        localparam int LW = DW >> (NLANES - 1 - g);
        logic [LW-1:0] sum_w;
        alu_lane_add #(.W(LW)) add_i (
            .p_i    (opnd_p[LW-1:0]),
            .q_i    (opnd_q[LW-1:0]),
            .cin_i  (carry_in),
            .sum_o  (sum_w),
            .cout_o (lane_cout[g]),
            .ovf_o  (lane_ovf[g])
        );
        if (LW < DW) begin : g_pad
            assign lane_sum[g] = {{(DW-LW){1'b0}}, sum_w};
        end else begin : g_full
            assign lane_sum[g] = sum_w;
        end
    end

    alu_size_sel #(.DW(DW)) sel_i (
        .size_i   (size_i),
        .dst_i    (dst_i),
        .sum_i    (lane_sum),
        .cout_i   (lane_cout),
        .ovf_i    (lane_ovf),
        .merged_o (merged),
        .msb_o    (s_msb),
        .zero_o   (s_zero),
        .cout_o   (s_cout),
        .ovf_o    (s_ovf)
    );

    // address add: always full width, narrow sizes sign-extend the low half
    always_comb begin
        if (size_i == SZ_BYTE || size_i == SZ_WORD)
            addr_src = {{(DW-HW){src_i[HW-1]}}, src_i[HW-1:0]};
        else
            addr_src = src_i;
        addr_sum = dst_i + addr_src;
    end

    always_comb begin
        case (op)
            OP_ADD, OP_ADDX, OP_SUB, OP_SUBX,
            OP_NEG, OP_NEGX, OP_CLR: res_o = merged;
            OP_ADDA:                 res_o = addr_sum;
            default:                 res_o = dst_i;
        endcase
    end

    // next-state for the condition codes
    always_comb begin
        st_d   = st_q;
        flag_c = is_sub ? ~s_cout : s_cout;
        if (exec_i) begin
            case (op)
                OP_ADD, OP_SUB, OP_NEG: begin
                    st_d.ccr.x = flag_c;
                    st_d.ccr.n = s_msb;
                    st_d.ccr.z = s_zero;
                    st_d.ccr.v = s_ovf;
                    st_d.ccr.c = flag_c;
                end
                OP_ADDX, OP_SUBX, OP_NEGX: begin
                    st_d.ccr.x = flag_c;
                    st_d.ccr.n = s_msb;
                    st_d.ccr.z = s_zero & st_q.ccr.z;
                    st_d.ccr.v = s_ovf;
                    st_d.ccr.c = flag_c;
                end
                OP_CMP: begin
                    st_d.ccr.n = s_msb;
                    st_d.ccr.z = s_zero;
                    st_d.ccr.v = s_ovf;
                    st_d.ccr.c = flag_c;
                end
                OP_CLR: begin
                    st_d.ccr.n = 1'b0;
                    st_d.ccr.z = 1'b1;
                    st_d.ccr.v = 1'b0;
                    st_d.ccr.c = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ccr_o = st_q.ccr;

endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          exec_i,
    input logic [3:0]    op_i,
    input logic [1:0]    size_i,
    input logic [DW-1:0] dst_i,
    input logic [DW-1:0] res_o,
    input logic [4:0]    ccr_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> ccr_o == 5'd0); // R1

    AST_UPPER_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd0 && op_i != 4'd8) |-> res_o[DW-1:DW/4] == dst_i[DW-1:DW/4]); // R2

    AST_UPPER_WORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (size_i == 2'd1 && op_i != 4'd8) |-> res_o[DW-1:DW/2] == dst_i[DW-1:DW/2]); // R2

    AST_X_TRACKS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == 4'd0 || op_i == 4'd2 || op_i == 4'd5))
        |=> ccr_o[4] == ccr_o[0]); // R4

    AST_XOP_X_TRACKS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == 4'd1 || op_i == 4'd3 || op_i == 4'd6))
        |=> ccr_o[4] == ccr_o[0]); // R5

    AST_STICKY_Z: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && (op_i == 4'd1 || op_i == 4'd3 || op_i == 4'd6) && !ccr_o[2])
        |=> !ccr_o[2]); // R5

    AST_CMP_KEEPS_X: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 4'd4) |=> ccr_o[4] == $past(ccr_o[4])); // R6

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4) |-> res_o == dst_i); // R6

    AST_CLR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 4'd7) |=> (ccr_o[3:0] == 4'b0100 && ccr_o[4] == $past(ccr_o[4]))); // R8

    AST_CLR_LONG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd7 && size_i[1]) |-> res_o == '0); // R8

    AST_ADDA_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_i && op_i == 4'd8) |=> $stable(ccr_o)); // R9

    AST_SPARE_OPS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i > 4'd8) |-> res_o == dst_i); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_i |=> $stable(ccr_o)); // R11
endmodule

bind alu_ccr_unit alu_ccr_chk #(.DW(DW)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .exec_i (exec_i),
    .op_i   (op_i),
    .size_i (size_i),
    .dst_i  (dst_i),
    .res_o  (res_o),
    .ccr_o  (ccr_o)
);

// File: tb/alu_ccr_unit_tb.sv
module alu_ccr_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;
    // {op4, size2, src32, dst32, xpre1, exp_res32, exp_ccr5}
    localparam int VW = 4 + 2 + 32 + 32 + 1 + 32 + 5;

    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd0, 2'd0, 32'h0000001E, 32'h12345677, 1'b0, 32'h12345695, 5'b01010}, // R4 byte overflow
        {4'd0, 2'd0, 32'h00000009, 32'hAABBCC95, 1'b1, 32'hAABBCC9E, 5'b01000}, // R4 no overflow
        {4'd0, 2'd1, 32'h00000001, 32'h1234FFFF, 1'b0, 32'h12340000, 5'b10101}, // R4 word carry
        {4'd0, 2'd2, 32'h00000001, 32'h7FFFFFFF, 1'b0, 32'h80000000, 5'b01010}, // R4 long overflow
        {4'd2, 2'd2, 32'h00000005, 32'h00000003, 1'b0, 32'hFFFFFFFE, 5'b11001}, // R4 borrow
        {4'd2, 2'd0, 32'h00000040, 32'hFFFFFF9E, 1'b0, 32'hFFFFFF5E, 5'b00010}, // R4 sub overflow
        {4'd2, 2'd1, 32'h00000001, 32'h00008000, 1'b0, 32'h00007FFF, 5'b00010}, // R4 word sub ovf
        {4'd1, 2'd0, 32'h00000000, 32'h000000FF, 1'b1, 32'h00000000, 5'b10101}, // R5 sticky Z kept
        {4'd1, 2'd1, 32'h00000001, 32'h00000000, 1'b1, 32'h00000002, 5'b00000}, // R5 Z cleared
        {4'd3, 2'd2, 32'h00000000, 32'h00000000, 1'b1, 32'hFFFFFFFF, 5'b11001}, // R5 borrow in
        {4'd4, 2'd1, 32'h000029AF, 32'h485C29AF, 1'b1, 32'h485C29AF, 5'b10100}, // R6 equal
        {4'd4, 2'd0, 32'h00000002, 32'h00000001, 1'b0, 32'h00000001, 5'b01001}, // R6 less
        {4'd5, 2'd0, 32'h00000000, 32'h052055C6, 1'b0, 32'h0520553A, 5'b10001}, // R7 negate
        {4'd5, 2'd0, 32'h00000000, 32'h00000080, 1'b0, 32'h00000080, 5'b11011}, // R7 min value
        {4'd6, 2'd0, 32'h00000000, 32'h00000000, 1'b1, 32'h000000FF, 5'b11001}, // R7 negx borrow
        {4'd6, 2'd1, 32'h00000000, 32'h00000000, 1'b0, 32'h00000000, 5'b00100}, // R7 negx zero
        {4'd7, 2'd1, 32'h00000000, 32'h12345678, 1'b1, 32'h12340000, 5'b10100}, // R8 clear word
        {4'd8, 2'd1, 32'hCE001A2B, 32'h00140300, 1'b1, 32'h00141D2B, 5'b10101}, // R9 word sext
        {4'd8, 2'd0, 32'h00008000, 32'h00000000, 1'b0, 32'hFFFF8000, 5'b00100}, // R9 negative sext
        {4'd9, 2'd0, 32'h11111111, 32'hDEADBEEF, 1'b1, 32'hDEADBEEF, 5'b10101}  // R10 spare op
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [3:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [31:0] res_o;
    logic [4:0]  ccr_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] res_cap;
    logic [4:0]  ccr_cap;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu_ccr_unit dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .exec_i (exec_i),
        .op_i   (op_i),
        .size_i (size_i),
        .src_i  (src_i),
        .dst_i  (dst_i),
        .res_o  (res_o),
        .ccr_o  (ccr_o)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s result act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic check5(input string req, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s ccr act=%b exp=%b", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic [1:0] sz,
                         input logic [31:0] s, input logic [31:0] d, input logic ex);
        @(negedge clk);
        op_i = op; size_i = sz; src_i = s; dst_i = d; exec_i = ex;
        #1 res_cap = res_o;
        @(posedge clk);
        #1 ccr_cap = ccr_o;
        exec_i = 1'b0;
    endtask

    // leaves ccr at 10101 (X=1) or 00100 (X=0)
    task automatic set_x(input logic xv);
        if (xv) do_op(4'd0, 2'd2, 32'hFFFFFFFF, 32'h00000001, 1'b1);
        else    do_op(4'd0, 2'd0, 32'h00000000, 32'h00000000, 1'b1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        check5("R1", ccr_o, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            set_x(v[37]);
            do_op(v[107:104], v[103:102], v[101:70], v[69:38], 1'b1);
            check32($sformatf("R2/R3 vec%0d", i), res_cap, v[36:5]);
            check5($sformatf("R3 vec%0d", i), ccr_cap, v[4:0]);
        end

        // R9 long size: no sign extension
        set_x(1'b0);
        do_op(4'd8, 2'd2, 32'hCE001A2B, 32'h00140300, 1'b1);
        check32("R9 long", res_cap, 32'hCE141D2B);
        check5("R9 long flags", ccr_cap, 5'b00100);

        // R8 clear byte and long, X held at 0
        set_x(1'b0);
        do_op(4'd7, 2'd0, 32'h0, 32'hCAFEBABE, 1'b1);
        check32("R8 byte", res_cap, 32'hCAFEBA00);
        check5("R8 byte flags", ccr_cap, 5'b00100);
        do_op(4'd7, 2'd3, 32'h0, 32'hCAFEBABE, 1'b1);
        check32("R8 long", res_cap, 32'h00000000);

        // R5 multi-word chain: low word zero with carry, high word zero -> Z stays 1
        set_x(1'b0);
        do_op(4'd1, 2'd1, 32'h00000001, 32'h0000FFFF, 1'b1);
        check5("R5 chain low", ccr_cap, 5'b10101);
        do_op(4'd1, 2'd1, 32'h0000FFFF, 32'h00000000, 1'b1);
        check32("R5 chain high", res_cap, 32'h00000000);
        check5("R5 chain high flags", ccr_cap, 5'b10101);

        // R11 exec low: flags hold despite a flag-changing op
        set_x(1'b1);
        do_op(4'd2, 2'd2, 32'h00000005, 32'h00000003, 1'b0);
        check5("R11 idle hold", ccr_cap, 5'b10101);
        check32("R11 result still combinational", res_cap, 32'hFFFFFFFE);

        // R1 mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        #1 check5("R1 async", ccr_o, 5'b00000);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule